// File: doc/BRIEF.md
# Unrolled Pipelined NLFSR Block Decryptor

This block decrypts a 32-bit block under a 64-bit key. The cipher is built from a nonlinear-feedback shift-register round, and every one of its 528 rounds is laid out in hardware. The rounds are grouped four to a registered stage, which gives a chain of 132 stages. The core accepts a new ciphertext and key pair on every clock. After a fixed latency it delivers one plaintext per clock, together with the key that produced it.

Each stage register carries three things: the data, a private copy of the key and a valid bit. Any mix of keys can therefore share the pipe at the same time. A typical use is an exhaustive key search, where a generator feeds candidate keys back to back and a comparator downstream watches the decrypted words. The core has no backpressure. A cycle with the input valid low simply becomes a bubble that moves through the pipe.

Top module: `nlfsr_unrolled_decryptor`

## Requirements
- R1: One decryption round shifts the 32-bit state left by one bit. The new bit 0 is the XOR of state bit 31, state bit 15, one key bit and g. The value g is bit n of the constant 0x3A5C742E, where the 5-bit index n = {s[30], s[25], s[19], s[8], s[0]} has s[30] as its most significant bit.
- R2: Round i, counted from 0 up to 527, uses key bit ((15 - i) mod 64).
- R3: Every valid output word equals the result of the 528 rounds of R1 and R2 applied in order to the ciphertext that was accepted with it.
- R4: A new pair is accepted on every cycle with the input valid high. An unbroken run of N valid inputs leaves the core as N valid outputs on N consecutive cycles.
- R5: The key output that goes with a valid result equals the key that was accepted with its ciphertext.
- R6: The latency is exactly 132 cycles, one per stage of 4 rounds. The output valid in cycle t equals the input valid in cycle t-132.
- R7: A cycle with the input valid low produces a cycle with the output valid low exactly 132 cycles later. Gaps between inputs are kept unchanged at the output.
- R8: During reset the output valid is low. After reset is released it stays low until the first accepted input emerges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the valid tracking |
| inValid | input | 1 | Ciphertext and key are presented this cycle |
| inCipher | input | 32 | Ciphertext block |
| inKey | input | 64 | Key for this block |
| outValid | output | 1 | Plaintext and key are valid this cycle |
| outPlain | output | 32 | Decrypted block |
| outKey | output | 64 | Key that was used for this block |

## Verification
A pair driven in slot n is captured at the clock edge that follows and passes through 132 stage registers. Its result therefore appears on the outputs in slot n+132. In every slot the bench first samples the outputs at the falling edge. It compares them with the record it kept for slot n-132, and only then drives slot n. This puts the valid bit, the plaintext (checked against a bench model of the rounds) and the key under check in exactly the cycle each one is due. In the first 132 slots after reset the only expected output is a low valid.

// File: rtl/nlfsr_dec_pkg.sv
package nlfsr_dec_pkg;

  localparam int BLOCK_W  = 32;
  localparam int KEY_W    = 64;
  localparam int NLF_IDX_W = 5;

  // feedback taps of the decryption round
  localparam int TAP_TOP  = 31;
  localparam int TAP_MID  = 15;
  localparam int NLF_A    = 30;
  localparam int NLF_B    = 25;
  localparam int NLF_C    = 19;
  localparam int NLF_D    = 8;
  localparam int NLF_E    = 0;

  // key bit offset for round zero; later rounds step downward modulo KEY_W
  localparam int KEY_TAP0 = 15;

  localparam logic [31:0] NLF_TABLE = 32'h3A5C742E;

  typedef struct packed {
    logic capture;
  } stageStrobe_t;

  function automatic int keyIndex(input int roundIdx);
    keyIndex = ((KEY_TAP0 - (roundIdx % KEY_W)) + KEY_W) % KEY_W;
  endfunction

endpackage

// File: rtl/nlfsr_dec_round.sv
module nlfsr_dec_round
  import nlfsr_dec_pkg::*;
(
  input  logic [BLOCK_W-1:0] stateIn,
  input  logic               keyBit,
  output logic [BLOCK_W-1:0] stateOut
);

  logic [NLF_IDX_W-1:0] nlfIdx;
  logic                 nlfBit;
  logic                 feedBit;

  always_comb begin
    nlfIdx   = {stateIn[NLF_A], stateIn[NLF_B], stateIn[NLF_C], stateIn[NLF_D], stateIn[NLF_E]};
    nlfBit   = NLF_TABLE[nlfIdx];
    feedBit  = stateIn[TAP_TOP] ^ stateIn[TAP_MID] ^ keyBit ^ nlfBit;
    stateOut = {stateIn[BLOCK_W-2:0], feedBit};
  end

endmodule

// File: rtl/nlfsr_dec_stage.sv
module nlfsr_dec_stage
  import nlfsr_dec_pkg::*;
#(
  parameter int STAGE_IDX = 0,
  parameter int RPS       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capture,
  input  logic [BLOCK_W-1:0] dataIn,
  input  logic [KEY_W-1:0]   keyIn,
  output logic [BLOCK_W-1:0] dataOut,
  output logic [KEY_W-1:0]   keyOut
);

  localparam int FIRST_ROUND = STAGE_IDX * RPS;

  logic [BLOCK_W-1:0] chain [RPS+1];

  assign chain[0] = dataIn;

  for (genvar j = 0; j < RPS; j++) begin : g_round
    localparam int KI = keyIndex(FIRST_ROUND + j);
    nlfsr_dec_round u_round (
      .stateIn (chain[j]),
      .keyBit  (keyIn[KI]),
      .stateOut(chain[j+1])
    );
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      dataOut <= chain[RPS];
      keyOut  <= keyIn;
    end
  end

  // R7: a bubble slot leaves the stage contents untouched
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> ($stable(dataOut) && $stable(keyOut)));

endmodule

// File: rtl/nlfsr_dec_datapath.sv
module nlfsr_dec_datapath
  import nlfsr_dec_pkg::*;
#(
  parameter int STAGES = 132,
  parameter int RPS    = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  stageStrobe_t [STAGES-1:0]      strobe,
  input  logic [BLOCK_W-1:0]             inCipher,
  input  logic [KEY_W-1:0]               inKey,
  output logic [BLOCK_W-1:0]             outPlain,
  output logic [KEY_W-1:0]               outKey
);

  logic [BLOCK_W-1:0] stData [STAGES+1];
  logic [KEY_W-1:0]   stKey  [STAGES+1];

  assign stData[0] = inCipher;
  assign stKey[0]  = inKey;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    nlfsr_dec_stage #(
      .STAGE_IDX(s),
      .RPS      (RPS)
    ) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .capture(strobe[s].capture),
      .dataIn (stData[s]),
      .keyIn  (stKey[s]),
      .dataOut(stData[s+1]),
      .keyOut (stKey[s+1])
    );
  end

  assign outPlain = stData[STAGES];
  assign outKey   = stKey[STAGES];

endmodule

// File: rtl/nlfsr_dec_ctrl.sv
module nlfsr_dec_ctrl
  import nlfsr_dec_pkg::*;
#(
  parameter int STAGES = 132
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output stageStrobe_t [STAGES-1:0] strobe,
  output logic                      outValid
);

  localparam int CNT_W = $clog2(STAGES + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STAGES);

  logic [STAGES-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobe[0].capture = inValid;
    for (int s = 1; s < STAGES; s++) strobe[s].capture = vPipe[s-1];
  end

  assign outValid = vPipe[STAGES-1];

  // checking state kept next to the valid chain
  logic [CNT_W-1:0] inFlight;
  logic [CNT_W-1:0] sinceReset;
  logic [CNT_W-1:0] streak;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight   <= '0;
      sinceReset <= '0;
      streak     <= '0;
    end else begin
      inFlight   <= inFlight + CNT_W'(inValid) - CNT_W'(outValid);
      if (sinceReset != CNT_MAX) sinceReset <= sinceReset + 1'b1;
      if (!inValid)              streak <= '0;
      else if (streak != CNT_MAX) streak <= streak + 1'b1;
    end
  end

  // R8: nothing emerges before the pipe could have filled
  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset < CNT_MAX) |-> !outValid);

  // R6: never more results in flight than stages
  a_r6_inflight_bound: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= CNT_MAX);

  // R6: a result leaving implies one was accepted earlier
  a_r6_out_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inFlight != '0));

  // R4: a full pipe of back-to-back inputs gives an output every cycle
  a_r4_full_stream: assert property (@(posedge clk) disable iff (!rstN)
    (streak >= CNT_MAX) |-> outValid);

endmodule

// File: rtl/nlfsr_unrolled_decryptor.sv
module nlfsr_unrolled_decryptor
  import nlfsr_dec_pkg::*;
#(
  parameter int ROUNDS = 528,
  parameter int RPS    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [BLOCK_W-1:0] inCipher,
  input  logic [KEY_W-1:0]   inKey,
  output logic               outValid,
  output logic [BLOCK_W-1:0] outPlain,
  output logic [KEY_W-1:0]   outKey
);

  localparam int STAGES = ROUNDS / RPS;

  stageStrobe_t [STAGES-1:0] strobe;

  nlfsr_dec_ctrl #(
    .STAGES(STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  nlfsr_dec_datapath #(
    .STAGES(STAGES),
    .RPS   (RPS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inCipher(inCipher),
    .inKey   (inKey),
    .outPlain(outPlain),
    .outKey  (outKey)
  );

endmodule

// File: tb/nlfsr_unrolled_decryptor_tb.sv
`timescale 1ns/1ps
module nlfsr_unrolled_decryptor_tb;

  localparam int LAT   = 132;
  localparam int NSLOT = 900;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inCipher = '0;
  logic [63:0] inKey = '0;
  logic        outValid;
  logic [31:0] outPlain;
  logic [63:0] outKey;

  always #2 clk = ~clk;

  nlfsr_unrolled_decryptor u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCipher(inCipher),
    .inKey(inKey), .outValid(outValid), .outPlain(outPlain), .outKey(outKey)
  );

  bit          expV [NSLOT];
  logic [31:0] expC [NSLOT];
  logic [63:0] expK [NSLOT];
  int checks = 0;
  int fails = 0;
  int slotN = 0;
  int nIn = 0;
  int nOut = 0;
  int run = 0;
  int maxRun = 0;
  bit done = 0;

  // R1 R2: bench model of the 528 decryption rounds
  function automatic logic [31:0] refDecrypt(input logic [31:0] c, input logic [63:0] k);
    logic [31:0] s = c;
    for (int i = 0; i < 528; i++) begin
      logic [4:0] idx = {s[30], s[25], s[19], s[8], s[0]};
      logic g = 1'(32'h3A5C742E >> idx);
      logic kb = k[(15 - i + 640) % 64];
      s = {s[30:0], s[31] ^ s[15] ^ kb ^ g};
    end
    return s;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s slot=%0d act=%h exp=%h", tag, slotN, act, exp);
    end
  endtask

  task automatic slot(input bit v, input logic [31:0] c, input logic [63:0] k);
    @(negedge clk);
    if (outValid) begin nOut++; run++; if (run > maxRun) maxRun = run; end
    else run = 0;
    if (slotN >= LAT) begin
      check("R6/R7 valid", 64'(outValid), 64'(expV[slotN-LAT]));
      if (expV[slotN-LAT]) begin
        check("R3 plaintext", 64'(outPlain), 64'(refDecrypt(expC[slotN-LAT], expK[slotN-LAT])));
        check("R5 key", outKey, expK[slotN-LAT]);
      end
    end else begin
      check("R8 quiet before fill", 64'(outValid), 64'd0);
    end
    expV[slotN] = v; expC[slotN] = c; expK[slotN] = k;
    if (v) nIn++;
    inValid = v; inCipher = c; inKey = k;
    slotN++;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) begin
      @(negedge clk);
      check("R8 in reset", 64'(outValid), 64'd0);
    end
    rstN = 1'b1;
    // directed corners
    slot(1, 32'h0, 64'h0);
    slot(1, 32'hFFFFFFFF, 64'hFFFFFFFF_FFFFFFFF);
    slot(0, 32'h12345678, 64'h1);
    slot(1, 32'h00000001, 64'h0);
    slot(1, 32'h0, 64'h0000_0000_0000_8000);   // R2: key bit 15 used first
    slot(1, 32'h0, 64'h8000_0000_0000_0000);
    slot(1, 32'hA5A5A5A5, 64'h01234567_89ABCDEF);
    // random with gaps
    for (int n = 0; n < 400; n++)
      slot(($urandom % 10) < 7, $urandom, {$urandom, $urandom});
    // R4: back-to-back burst
    for (int n = 0; n < 64; n++)
      slot(1, $urandom, {$urandom, $urandom});
    slot(0, 32'h0, 64'h0);
    for (int n = 0; n < 20; n++)
      slot(($urandom % 2) == 0, $urandom, {$urandom, $urandom});
    // flush
    for (int n = 0; n < LAT + 4; n++)
      slot(0, $urandom, {$urandom, $urandom});
    check("R4 outputs equal inputs", 64'(nOut), 64'(nIn));
    checks++;
    if (maxRun < 64) begin
      fails++;
      $display("FAIL R4 longest output run act=%0d exp>=%0d", maxRun, 64);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4 act=%0d exp=%0d slots", slotN, NSLOT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule